// File: doc/BRIEF.md
# Marker-Aligned Lane Deskew Unit

This block sits at the receive side of a wide parallel die-to-die link whose lanes can arrive up to three clock cycles apart. Every lane carries a data word and a one-bit marker flag, and the sender places a marker on all lanes once every 16 cycles. The unit groups lanes into bundles according to a per-octet topology setting. For each bundle it timestamps the marker on every member lane and takes the latest lane as the reference. It then holds each earlier lane in a short delay line so that all members of the bundle leave the block in the same cycle.

Measurement runs again on every marker, so a change in skew is tracked without a reset. Each bundle slot has two flags. The aligned flag reports that the bundle's delays are valid. The skew-error flag reports that a marker window closed before every member lane had shown its marker. Lanes configured as single-lane links bypass deskew entirely. Topology is static and is captured only while reset is held.

Top module: `lane_deskew`

## Requirements
- R1: Every lane output is registered: with a lane delay of d (0 to 3), the word and marker presented on a lane input in cycle t appear on that lane's output in cycle t+1+d.
- R2: Within a bundle, the lane whose marker arrives last gets delay 0, and every other lane gets the number of cycles by which its marker preceded that last one. After alignment, all lanes of the bundle present the same marker and data in the same cycle, with a latency of 1 plus the bundle's largest skew.
- R3: Each marker starts a fresh measurement. If the lane skew changes, the new delays replace the old ones at the next clean marker, and the bundle realigns without a reset.
- R4: Reset clears all delays, output registers, aligned flags and error flags. The topology input `topo_i` is captured only while `rst` is high, and changes at other times have no effect.
- R5: Lanes 0–7 form octet 0 and lanes 8–15 form octet 1. No bundle spans both octets, and each octet is aligned independently of the other. Flag bit index = octet*4 + slot.
- R6: The topology code for octet o sits at `topo_i[2o+1:2o]`. Code 0: one 8-lane bundle in slot 0. Code 1: slot 0 holds lanes 0–3 and slot 1 holds lanes 4–7 of the octet. Code 2: slot k holds lanes 2k and 2k+1. Code 3: single-lane links. Flags of unused slots stay 0.
- R7: In an octet with code 3, every lane passes through with delay 0, and all four flag pairs of that octet stay 0.
- R8: Suppose the first marker of a window reaches a bundle in cycle c and some member lane has shown no marker by cycle c+3. Then the skew-error flag is set at the edge that ends cycle c+3, the aligned flag is cleared, and the lane delays keep their previous values. The error flag stays set until the next successful alignment of that bundle.
- R9: The aligned flag rises at the edge that ends the cycle in which the last member marker arrives. It stays high through every later successful alignment.
- R10: When all member markers of a bundle arrive in the same cycle, the alignment completes at the end of that cycle with all delays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset; topology is captured while it is high |
| topo_i | input | 2*NUM_OCTETS | Per-octet topology code |
| lane_data_i | input | NUM_OCTETS*8*DATA_W | Lane data words, lane i at bits [i*DATA_W +: DATA_W] |
| lane_mark_i | input | NUM_OCTETS*8 | Marker flag per lane |
| out_data_o | output | NUM_OCTETS*8*DATA_W | Aligned lane data words |
| out_mark_o | output | NUM_OCTETS*8 | Aligned marker flag per lane |
| bundle_aligned_o | output | NUM_OCTETS*4 | Aligned flag per bundle slot |
| skew_err_o | output | NUM_OCTETS*4 | Skew-error flag per bundle slot |

## Verification
Skew of exactly three cycles is driven as the widest legal case, and four cycles as the first illegal one. A window that is off by one would either reject a legal bundle or accept an illegal one and load a delay the line cannot hold. A lane whose marker is withheld after alignment checks that an error keeps the delays: a design that reloaded them would scatter the data on the surviving lanes. Mixed topologies in the two octets, with different reference skews per bundle, expose any grouping that leaks across a bundle or octet boundary. A first marker with zero skew checks that the aligned flag rises exactly one edge later. A late flag points to an extra window cycle; a flag that never rises points to a missed same-cycle completion.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    localparam int LANES_PER_OCTET = 8;
    localparam int SLOTS_PER_OCTET = 4;

    typedef enum logic [1:0] {
        TOPO_X8 = 2'd0,
        TOPO_X4 = 2'd1,
        TOPO_X2 = 2'd2,
        TOPO_X1 = 2'd3
    } topo_e;

    // Lanes of an octet that belong to a bundle slot under a topology.
    function automatic logic [LANES_PER_OCTET-1:0] slot_mask(topo_e topo, logic [1:0] slot);
        logic [LANES_PER_OCTET-1:0] m;
        m = '0;
        case (topo)
            TOPO_X8: if (slot == 2'd0) m = 8'hFF;
            TOPO_X4: if (slot == 2'd0) m = 8'h0F;
                     else if (slot == 2'd1) m = 8'hF0;
            TOPO_X2: m = 8'(8'h03 << {slot, 1'b0});
            default: m = '0;
        endcase
        return m;
    endfunction

    // Bundle slot that owns a lane of an octet.
    function automatic logic [1:0] lane_slot(topo_e topo, logic [2:0] lane);
        logic [1:0] s;
        case (topo)
            TOPO_X4: s = {1'b0, lane[2]};
            TOPO_X2: s = lane[2:1];
            default: s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lane_delay.sv
module lane_delay #(
    parameter int DATA_W   = 8,
    parameter int MAX_SKEW = 3,
    localparam int W       = DATA_W + 1,
    localparam int SEL_W   = $clog2(MAX_SKEW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mark_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W-1:0] data_o,
    output logic              mark_o
);

    typedef struct packed {
        logic [MAX_SKEW-1:0][W-1:0] hist;
        logic [W-1:0]               out;
    } dly_st_t;

    dly_st_t st_d, st_q;
    logic [W-1:0] tap;

    always_comb begin
        st_d = st_q;
        tap  = {mark_i, data_i};
        for (int k = 1; k <= MAX_SKEW; k++) begin
            if (int'(sel_i) == k) tap = st_q.hist[k-1];
        end
        st_d.hist[0] = {mark_i, data_i};
        for (int k = 1; k < MAX_SKEW; k++) begin
            st_d.hist[k] = st_q.hist[k-1];
        end
        st_d.out = tap;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign {mark_o, data_o} = st_q.out;

    AST_SEL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        int'(sel_i) <= MAX_SKEW); // R1
    AST_PASS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel_i == '0) |=> ({mark_o, data_o} == $past({mark_i, data_i}))); // R1

endmodule

// File: rtl/bundle_ctrl.sv
module bundle_ctrl #(
    parameter int LANES    = 8,
    parameter int MAX_SKEW = 3,
    localparam int CNT_W   = $clog2(MAX_SKEW + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            mask_i,
    input  logic [LANES-1:0]            mark_i,
    output logic [LANES-1:0][CNT_W-1:0] dly_o,
    output logic                        aligned_o,
    output logic                        err_o
);

    typedef struct packed {
        logic                        busy;
        logic [CNT_W-1:0]            cnt;
        logic [LANES-1:0]            seen;
        logic [LANES-1:0][CNT_W-1:0] stamp;
        logic [LANES-1:0][CNT_W-1:0] dly;
        logic                        aligned;
        logic                        err;
    } bnd_st_t;

    bnd_st_t st_d, st_q;
    logic [LANES-1:0]            prior, arrive, seen_all;
    logic [LANES-1:0][CNT_W-1:0] stamp_n;
    logic [CNT_W-1:0]            cur;

    always_comb begin
        st_d     = st_q;
        prior    = st_q.busy ? st_q.seen : '0;
        arrive   = mark_i & mask_i & ~prior;
        seen_all = prior | arrive;
        cur      = st_q.busy ? st_q.cnt : '0;
        stamp_n  = st_q.stamp;
        for (int i = 0; i < LANES; i++) begin
            if (arrive[i]) stamp_n[i] = cur;
        end
        if ((mask_i != '0) && (st_q.busy || (arrive != '0))) begin
            if ((seen_all & mask_i) == mask_i) begin
                for (int i = 0; i < LANES; i++) begin
                    st_d.dly[i] = mask_i[i] ? CNT_W'(cur - stamp_n[i]) : '0;
                end
                st_d.aligned = 1'b1;
                st_d.err     = 1'b0;
                st_d.busy    = 1'b0;
            end else if (cur == CNT_W'(MAX_SKEW)) begin
                st_d.err     = 1'b1;
                st_d.aligned = 1'b0;
                st_d.busy    = 1'b0;
            end else begin
                st_d.busy  = 1'b1;
                st_d.cnt   = cur + 1'b1;
                st_d.seen  = seen_all;
                st_d.stamp = stamp_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dly_o     = st_q.dly;
    assign aligned_o = st_q.aligned;
    assign err_o     = st_q.err;

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> (st_q.cnt <= CNT_W'(MAX_SKEW))); // R8
    AST_ERR_KEEPS_DELAYS: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.err) |-> $stable(st_q.dly)); // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(aligned_o && err_o)); // R9
    AST_EMPTY_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_i == '0) |-> (!aligned_o && !err_o && !st_q.busy)); // R6

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
    import deskew_pkg::*;
#(
    parameter int NUM_OCTETS = 2,
    parameter int DATA_W     = 8,
    parameter int MAX_SKEW   = 3,
    localparam int LPO       = LANES_PER_OCTET,
    localparam int SPO       = SLOTS_PER_OCTET,
    localparam int NUM_LANES = NUM_OCTETS * LPO,
    localparam int NUM_SLOTS = NUM_OCTETS * SPO,
    localparam int DLY_W     = $clog2(MAX_SKEW + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [2*NUM_OCTETS-1:0]       topo_i,
    input  logic [NUM_LANES*DATA_W-1:0]   lane_data_i,
    input  logic [NUM_LANES-1:0]          lane_mark_i,
    output logic [NUM_LANES*DATA_W-1:0]   out_data_o,
    output logic [NUM_LANES-1:0]          out_mark_o,
    output logic [NUM_SLOTS-1:0]          bundle_aligned_o,
    output logic [NUM_SLOTS-1:0]          skew_err_o
);

    typedef struct packed {
        topo_e [NUM_OCTETS-1:0] topo;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            for (int o = 0; o < NUM_OCTETS; o++) begin
                st_d.topo[o] = topo_e'(topo_i[2*o +: 2]);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    logic [LPO-1:0][DLY_W-1:0] slot_dly [NUM_OCTETS][SPO];
    logic [DLY_W-1:0]          lane_sel [NUM_LANES];

    for (genvar o = 0; o < NUM_OCTETS; o++) begin : g_oct
        for (genvar s = 0; s < SPO; s++) begin : g_slot
            logic [LPO-1:0] mask;
            assign mask = slot_mask(st_q.topo[o], 2'(s));
            bundle_ctrl #(
                .LANES    (LPO),
                .MAX_SKEW (MAX_SKEW)
            ) u_bnd (
                .clk       (clk),
                .rst       (rst),
                .mask_i    (mask),
                .mark_i    (lane_mark_i[o*LPO +: LPO]),
                .dly_o     (slot_dly[o][s]),
                .aligned_o (bundle_aligned_o[o*SPO + s]),
                .err_o     (skew_err_o[o*SPO + s])
            );
        end

        for (genvar l = 0; l < LPO; l++) begin : g_lane
            logic [1:0] owner;
            assign owner = lane_slot(st_q.topo[o], 3'(l));
            assign lane_sel[o*LPO + l] = (st_q.topo[o] == TOPO_X1) ? '0
                                       : slot_dly[o][owner][l];
            lane_delay #(
                .DATA_W   (DATA_W),
                .MAX_SKEW (MAX_SKEW)
            ) u_dly (
                .clk    (clk),
                .rst    (rst),
                .data_i (lane_data_i[(o*LPO + l)*DATA_W +: DATA_W]),
                .mark_i (lane_mark_i[o*LPO + l]),
                .sel_i  (lane_sel[o*LPO + l]),
                .data_o (out_data_o[(o*LPO + l)*DATA_W +: DATA_W]),
                .mark_o (out_mark_o[o*LPO + l])
            );
        end

        AST_X1_FLAGS_LOW: assert property (@(posedge clk) disable iff (rst)
            (st_q.topo[o] == TOPO_X1) |->
            (bundle_aligned_o[o*SPO +: SPO] == '0 && skew_err_o[o*SPO +: SPO] == '0)); // R7
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bundle_aligned_o == '0 && skew_err_o == '0 && out_mark_o == '0)); // R4
    AST_TOPO_STATIC: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(st_q.topo)); // R4

endmodule

// File: tb/lane_deskew_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_tb_top;

    localparam int NL = 16;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        topo_r = 4'd0;
    logic [NL*DW-1:0]  lane_data = '0;
    logic [NL-1:0]     lane_mark = '0;
    logic [NL*DW-1:0]  out_data;
    logic [NL-1:0]     out_mark;
    logic [7:0]        aligned;
    logic [7:0]        err;

    int skew [NL];
    bit mken [NL];
    int t = 100;
    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lane_deskew dut_i (
        .clk              (clk),
        .rst              (rst),
        .topo_i           (topo_r),
        .lane_data_i      (lane_data),
        .lane_mark_i      (lane_mark),
        .out_data_o       (out_data),
        .out_mark_o       (out_mark),
        .bundle_aligned_o (aligned),
        .skew_err_o       (err)
    );

    task automatic drive();
        for (int i = 0; i < NL; i++) begin
            lane_data[i*DW +: DW] = 8'(t - skew[i]);
            lane_mark[i] = mken[i] && (((t - skew[i]) % 16) == 0);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            t++;
            drive();
        end
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0d)", req, act, exp, t);
        end
    endtask

    task automatic set_skews(int o, int s0, int s1, int s2, int s3, int s4, int s5, int s6, int s7);
        skew[o*8+0] = s0; skew[o*8+1] = s1; skew[o*8+2] = s2; skew[o*8+3] = s3;
        skew[o*8+4] = s4; skew[o*8+5] = s5; skew[o*8+6] = s6; skew[o*8+7] = s7;
    endtask

    task automatic do_reset(logic [3:0] topo);
        rst = 1'b1;
        topo_r = topo;
        step(3);
        rst = 1'b0;
    endtask

    // Lanes lo..hi must all show the input of cycle (t-1-ref) for 16 cycles.
    task automatic check_bundle(int lo, int hi, int ref_skew, string req);
        int bad = 0;
        int act = 0;
        int exp = 0;
        for (int k = 0; k < 16; k++) begin
            step(1);
            for (int i = lo; i <= hi; i++) begin
                logic [7:0] e;
                bit em;
                e  = 8'(t - 1 - ref_skew);
                em = mken[i] && (((t - 1 - ref_skew) % 16) == 0);
                if (out_data[i*DW +: DW] != e || out_mark[i] != em) begin
                    bad++;
                    act = int'(out_data[i*DW +: DW]);
                    exp = int'(e);
                end
            end
        end
        check(bad == 0, req, act, exp);
    endtask

    task automatic test_reset();
        for (int i = 0; i < NL; i++) begin skew[i] = 0; mken[i] = 1'b1; end
        rst = 1'b1;
        drive();
        step(4);
        check(aligned == 8'h00, "R4 aligned clear in reset", int'(aligned), 0);
        check(err == 8'h00, "R4 error clear in reset", int'(err), 0);
        check(out_mark == '0, "R4 output markers clear in reset", int'(out_mark), 0);
    endtask

    task automatic test_x16();
        set_skews(0, 0, 1, 2, 3, 0, 1, 2, 3);
        set_skews(1, 2, 0, 0, 1, 0, 0, 0, 0);
        do_reset(4'b0000);
        step(40);
        check(aligned == 8'h11, "R6 R9 x8 slot flags", int'(aligned), 'h11);
        check(err == 8'h00, "R8 no error at skew 3", int'(err), 0);
        check_bundle(0, 7, 3, "R2 octet0 aligned at skew 3");
        check_bundle(8, 15, 2, "R5 octet1 aligned independently");
    endtask

    task automatic test_remeasure();
        set_skews(0, 3, 2, 1, 0, 0, 0, 0, 1);
        step(48);
        check(aligned[0] == 1'b1 && err[0] == 1'b0, "R3 realigned after skew change",
              int'({err[0], aligned[0]}), 1);
        check_bundle(0, 7, 3, "R3 new delays in effect");
    endtask

    task automatic test_error();
        set_skews(0, 0, 1, 2, 3, 0, 1, 2, 3);
        step(40);
        mken[5] = 1'b0;
        step(20);
        check(err[0] == 1'b1, "R8 error on missing marker", int'(err[0]), 1);
        check(aligned[0] == 1'b0, "R8 aligned dropped on error", int'(aligned[0]), 0);
        check_bundle(0, 7, 3, "R8 delays kept after error");
        mken[5] = 1'b1;
        step(40);
        check(err[0] == 1'b0 && aligned[0] == 1'b1, "R9 recovery after error",
              int'({err[0], aligned[0]}), 1);
    endtask

    task automatic test_mixed();
        set_skews(0, 0, 2, 1, 0, 1, 1, 3, 0);
        set_skews(1, 0, 4, 0, 0, 2, 0, 1, 3);
        do_reset(4'b1001);
        step(48);
        check(aligned == 8'hE3, "R6 x4 and x2 slot flags", int'(aligned), 'hE3);
        check(err == 8'h10, "R8 skew of 4 flagged", int'(err), 'h10);
        check_bundle(0, 3, 2, "R6 x4 bundle lanes 0-3");
        check_bundle(4, 7, 3, "R6 x4 bundle lanes 4-7");
        check_bundle(10, 11, 0, "R10 zero-skew x2 bundle");
        check_bundle(12, 13, 2, "R6 x2 bundle lanes 12-13");
        check_bundle(14, 15, 3, "R6 x2 bundle lanes 14-15");
    endtask

    task automatic test_x1();
        int bad = 0;
        set_skews(0, 0, 1, 2, 3, 1, 0, 3, 2);
        set_skews(1, 0, 0, 0, 0, 0, 0, 0, 0);
        do_reset(4'b1011);
        topo_r = 4'b0000;
        while ((t % 16) != 0) step(1);
        check(aligned[4] == 1'b0, "R10 not aligned before first marker", int'(aligned[4]), 0);
        step(1);
        check(aligned[4] == 1'b1, "R10 aligned one edge after zero-skew marker", int'(aligned[4]), 1);
        for (int k = 0; k < 20; k++) begin
            step(1);
            for (int i = 0; i < 8; i++) begin
                if (out_data[i*DW +: DW] != 8'(t - 1 - skew[i])) bad++;
            end
        end
        check(bad == 0, "R7 x1 lanes pass with delay 0", bad, 0);
        check(R1_latency_ok(), "R1 one-cycle latency at delay 0", int'(out_data[7:0]), t - 1);
        check(aligned[3:0] == 4'h0 && err[3:0] == 4'h0, "R7 x1 flags low",
              int'({err[3:0], aligned[3:0]}), 0);
        check(aligned[7:4] == 4'hF, "R4 topology change after reset ignored",
              int'(aligned[7:4]), 'hF);
    endtask

    function automatic bit R1_latency_ok();
        return out_data[7:0] == 8'(t - 1 - skew[0]);
    endfunction

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset();
        test_x16();
        test_remeasure();
        test_error();
        test_mixed();
        test_x1();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule